// File: doc/BRIEF.md
# Element-Indexed Vector Register File

This block stores a set of vector registers, each VLEN bits wide, and lets a datapath reach any element by naming a register and an element index. The element width comes from a shared two-bit code and may be 8, 16, 32 or 64 bits. The registers sit back to back in one byte array. An element index larger than one register can hold runs on into the following registers, so a group of consecutive registers can be treated as one long vector with no extra address logic in the caller.

There is one write port and one read port. A write changes only the bytes of the addressed element. A read returns the element one cycle later, zero-extended or sign-extended to 64 bits. Each register has a sticky "touched" flag. Any in-range access to that register sets it, and only reset clears it. An access whose effective register falls past the last register raises an error pulse and leaves storage and flags alone.

Top module: `velem_regfile`

## Requirements
- R1: Reset clears every bit of `ref_flags`. Reset does not alter the register contents, so data written before reset reads back unchanged after it.
- R2: The width code `cfg_sew` selects the element size: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes and 3 gives 8 bytes. A register holds (VLEN/8)/size elements.
- R3: The effective register is the given register plus index/(elements per register). The element slot inside that register is index modulo (elements per register). Byte k of an element lies at byte k of its slot, so element bytes are little-endian.
- R4: A write changes only the bytes of the addressed element. Every other byte of the file keeps its value.
- R5: Read data appears on `rd_data` in the cycle after `rd_en`. With `rd_signed` high the element is sign-extended to 64 bits; with it low the element is zero-extended. `rd_data` holds its value in cycles without a read.
- R6: A read and a write in the same cycle to the same element return the contents from before the write.
- R7: An in-range read or write sets the `ref_flags` bit of its effective register, visible in the cycle after the access. The bit stays set until reset.
- R8: When the effective register is at or past NREG, the access is out of range. An out-of-range write pulses `wr_err` in the next cycle and changes no storage. An out-of-range read pulses `rd_err` in the next cycle and returns zero. Neither kind sets a flag. In-range accesses never raise either error.
- R9: Bits of `wr_data` above the element width are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sew | input | 2 | Element width code, shared by both ports |
| wr_en | input | 1 | Write request |
| wr_reg | input | REG_W | Write base register |
| wr_idx | input | IDX_W | Write element index |
| wr_data | input | 64 | Write element value in the low bits |
| rd_en | input | 1 | Read request |
| rd_reg | input | REG_W | Read base register |
| rd_idx | input | IDX_W | Read element index |
| rd_signed | input | 1 | Sign-extend the read element when high |
| rd_data | output | 64 | Extended read element |
| rd_err | output | 1 | Previous read was out of range |
| wr_err | output | 1 | Previous write was out of range |
| ref_flags | output | NREG | Sticky per-register touched flags |

## Verification
The bench writes an element through one register and index and reads it back through a different register and index that alias the same bytes. A design that got the spill arithmetic or the byte order wrong would return a different value. It also targets writes that just overrun the last register. A design missing the range guard would wrap the write onto register zero and corrupt data that a later read exposes. Same-cycle read and write of one element catch a design that forwards the new data. Narrow signed reads with the top bit set catch missing sign extension. A second reset after filling the file shows that the flags clear while the data stays.

// File: rtl/velem_pkg.sv
package velem_pkg;

  typedef enum logic [1:0] {
    SEW_B8  = 2'd0,
    SEW_B16 = 2'd1,
    SEW_B32 = 2'd2,
    SEW_B64 = 2'd3
  } sew_code_e;

  // number of bytes in one element for a width code
  function automatic logic [3:0] elem_bytes(input logic [1:0] sew);
    return 4'(4'd1 << sew);
  endfunction

  // log2 of elements held by one register
  function automatic int unsigned log_epr(input int unsigned log_bpr, input logic [1:0] sew);
    return log_bpr - int'(sew);
  endfunction

  // register the element really lands in, after spilling
  function automatic int unsigned spill_reg(input int unsigned base_reg, input int unsigned idx,
                                            input int unsigned lg_epr);
    return base_reg + (idx >> lg_epr);
  endfunction

  // element slot inside the effective register
  function automatic int unsigned spill_slot(input int unsigned idx, input int unsigned lg_epr);
    return idx & ((32'd1 << lg_epr) - 32'd1);
  endfunction

  // widen a raw little-endian element to 64 bits
  function automatic logic [63:0] widen_elem(input logic [63:0] raw, input logic [1:0] sew,
                                             input logic sgn);
    logic [63:0] res;
    case (sew)
      2'd0:    res = {{56{sgn & raw[7]}},  raw[7:0]};
      2'd1:    res = {{48{sgn & raw[15]}}, raw[15:0]};
      2'd2:    res = {{32{sgn & raw[31]}}, raw[31:0]};
      default: res = raw;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/velem_addr_map.sv
module velem_addr_map
  import velem_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int VLEN  = 128,
  parameter int IDX_W = 9,
  localparam int REG_W   = $clog2(NREG),
  localparam int BPR     = VLEN / 8,
  localparam int LOG_BPR = $clog2(BPR),
  localparam int TOTAL   = NREG * BPR,
  localparam int BA_W    = $clog2(TOTAL)
) (
  input  logic [1:0]       sew,
  input  logic [REG_W-1:0] base_reg,
  input  logic [IDX_W-1:0] idx,
  output logic [31:0]      eff_reg,
  output logic [BA_W-1:0]  byte_addr,
  output logic [3:0]       nbytes,
  output logic             oob
);
  int unsigned lg_epr;
  int unsigned slot;
  int unsigned full_addr;

  always_comb begin
    lg_epr    = log_epr(LOG_BPR, sew);
    eff_reg   = spill_reg(32'(base_reg), 32'(idx), lg_epr);
    slot      = spill_slot(32'(idx), lg_epr);
    full_addr = eff_reg * BPR + (slot << sew);
    byte_addr = BA_W'(full_addr);
    nbytes    = elem_bytes(sew);
    oob       = (eff_reg >= NREG);
  end
endmodule

// File: rtl/velem_store.sv
module velem_store #(
  parameter int TOTAL = 512,
  localparam int BA_W = $clog2(TOTAL)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [BA_W-1:0] wr_addr,
  input  logic [3:0]      wr_nbytes,
  input  logic [63:0]     wr_word,
  input  logic [BA_W-1:0] rd_addr,
  output logic [63:0]     rd_word
);
  logic [7:0] mem [TOTAL];

  // byte-lane write: lanes beyond the element size stay untouched
  always_ff @(posedge clk) begin
    for (int k = 0; k < 8; k++) begin
      if (we && (4'(k) < wr_nbytes))
        mem[BA_W'(wr_addr + BA_W'(k))] <= wr_word[8*k +: 8];
    end
  end

  // eight consecutive bytes; lanes past the element are dropped by the caller
  always_comb begin
    for (int k = 0; k < 8; k++)
      rd_word[8*k +: 8] = mem[BA_W'(rd_addr + BA_W'(k))];
  end
endmodule

// File: rtl/velem_touch.sv
module velem_touch #(
  parameter int NREG = 32,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_a,
  input  logic [REG_W-1:0] reg_a,
  input  logic             hit_b,
  input  logic [REG_W-1:0] reg_b,
  output logic [NREG-1:0]  flags
);
  for (genvar g = 0; g < NREG; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flags[g] <= 1'b0;
      else if ((hit_a && reg_a == REG_W'(g)) || (hit_b && reg_b == REG_W'(g)))
        flags[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/velem_regfile.sv
module velem_regfile
  import velem_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int VLEN  = 128,
  parameter int IDX_W = 9,
  localparam int REG_W = $clog2(NREG),
  localparam int BPR   = VLEN / 8,
  localparam int TOTAL = NREG * BPR,
  localparam int BA_W  = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_sew,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_reg,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [63:0]      wr_data,
  input  logic             rd_en,
  input  logic [REG_W-1:0] rd_reg,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_signed,
  output logic [63:0]      rd_data,
  output logic             rd_err,
  output logic             wr_err,
  output logic [NREG-1:0]  ref_flags
);
  // named internal events for the checker
  logic [31:0]     wr_eff, rd_eff;
  logic [BA_W-1:0] wr_addr, rd_addr;
  logic [3:0]      wr_nbytes, rd_nbytes;
  logic            wr_oob, rd_oob;
  logic            wr_commit, rd_commit;
  logic [63:0]     raw_word, shaped;

  velem_addr_map #(.NREG(NREG), .VLEN(VLEN), .IDX_W(IDX_W)) u_wmap (
    .sew(cfg_sew), .base_reg(wr_reg), .idx(wr_idx),
    .eff_reg(wr_eff), .byte_addr(wr_addr), .nbytes(wr_nbytes), .oob(wr_oob)
  );

  velem_addr_map #(.NREG(NREG), .VLEN(VLEN), .IDX_W(IDX_W)) u_rmap (
    .sew(cfg_sew), .base_reg(rd_reg), .idx(rd_idx),
    .eff_reg(rd_eff), .byte_addr(rd_addr), .nbytes(rd_nbytes), .oob(rd_oob)
  );

  assign wr_commit = wr_en && !wr_oob;
  assign rd_commit = rd_en && !rd_oob;

  velem_store #(.TOTAL(TOTAL)) u_store (
    .clk(clk), .we(wr_commit), .wr_addr(wr_addr), .wr_nbytes(wr_nbytes),
    .wr_word(wr_data), .rd_addr(rd_addr), .rd_word(raw_word)
  );

  velem_touch #(.NREG(NREG)) u_touch (
    .clk(clk), .rst_n(rst_n),
    .hit_a(rd_commit), .reg_a(rd_eff[REG_W-1:0]),
    .hit_b(wr_commit), .reg_b(wr_eff[REG_W-1:0]),
    .flags(ref_flags)
  );

  assign shaped = widen_elem(raw_word, cfg_sew, rd_signed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_err  <= 1'b0;
      wr_err  <= 1'b0;
    end else begin
      rd_err <= rd_en && rd_oob;
      wr_err <= wr_en && wr_oob;
      if (rd_en) rd_data <= rd_oob ? 64'd0 : shaped;
    end
  end

  logic [3:0] unused_rd_nbytes;
  assign unused_rd_nbytes = rd_nbytes;
endmodule

// File: rtl/velem_regfile_chk.sv
module velem_regfile_chk #(
  parameter int NREG = 32,
  localparam int REG_W = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      cfg_sew,
  input logic            rd_en,
  input logic            rd_signed,
  input logic [63:0]     rd_data,
  input logic            rd_err,
  input logic            wr_en,
  input logic            wr_err,
  input logic [NREG-1:0] ref_flags,
  input logic            rd_oob,
  input logic            wr_oob,
  input logic [31:0]     rd_eff,
  input logic [31:0]     wr_eff
);
  logic [NREG-1:0] rd_hot, wr_hot;
  assign rd_hot = NREG'(1) << rd_eff[REG_W-1:0];
  assign wr_hot = NREG'(1) << wr_eff[REG_W-1:0];

  a_r1_flags_clear: assert property (@(posedge clk) $rose(rst_n) |-> ref_flags == '0);

  a_r7_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ref_flags) & ~ref_flags) == '0);

  a_r7_read_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_oob) |=> (ref_flags & $past(rd_hot)) != '0);

  a_r7_write_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_oob) |=> (ref_flags & $past(wr_hot)) != '0);

  a_r8_read_range: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_oob) |=> (rd_err && rd_data == 64'd0));

  a_r8_write_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_oob) |=> wr_err);

  a_r8_no_false_err: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_oob) |=> !rd_err);

  a_r5_zero_extend: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_signed && cfg_sew == 2'd0) |=> rd_data[63:8] == '0);

  a_r5_sign_extend: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_signed && !rd_oob && cfg_sew == 2'd1) |=> rd_data[63:16] == {48{rd_data[15]}});
endmodule

bind velem_regfile velem_regfile_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_sew(cfg_sew), .rd_en(rd_en), .rd_signed(rd_signed),
  .rd_data(rd_data), .rd_err(rd_err), .wr_en(wr_en), .wr_err(wr_err),
  .ref_flags(ref_flags), .rd_oob(rd_oob), .wr_oob(wr_oob), .rd_eff(rd_eff), .wr_eff(wr_eff)
);

// File: tb/velem_regfile_bench.sv
module velem_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREG  = 32;
  localparam int VLEN  = 128;
  localparam int IDX_W = 9;
  localparam int REG_W = $clog2(NREG);
  localparam int BPR   = VLEN / 8;
  localparam int TOTAL = NREG * BPR;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       cfg_sew = 2'd0;
  logic             wr_en = 1'b0;
  logic [REG_W-1:0] wr_reg = '0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [63:0]      wr_data = '0;
  logic             rd_en = 1'b0;
  logic [REG_W-1:0] rd_reg = '0;
  logic [IDX_W-1:0] rd_idx = '0;
  logic             rd_signed = 1'b0;
  logic [63:0]      rd_data;
  logic             rd_err, wr_err;
  logic [NREG-1:0]  ref_flags;

  int checks = 0;
  int errors = 0;
  logic [7:0]      model [TOTAL];
  logic [NREG-1:0] mflags = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  velem_regfile #(.NREG(NREG), .VLEN(VLEN), .IDX_W(IDX_W)) u_velem_regfile (
    .clk(clk), .rst_n(rst_n), .cfg_sew(cfg_sew),
    .wr_en(wr_en), .wr_reg(wr_reg), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_signed(rd_signed),
    .rd_data(rd_data), .rd_err(rd_err), .wr_err(wr_err), .ref_flags(ref_flags)
  );

  // flat byte position: contiguous registers, so reg*bytes + idx*size
  function automatic int flat_pos(int r, int i, int sew);
    return r * BPR + i * (1 << sew);
  endfunction

  function automatic logic [63:0] model_read(int pos, int sew, logic sgn);
    logic [63:0] v = '0;
    int nb = 1 << sew;
    for (int k = 0; k < nb; k++) v[8*k +: 8] = model[pos + k];
    if (sgn && v[8*nb-1]) for (int b = 8*nb; b < 64; b++) v[b] = 1'b1;
    return v;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // one cycle with optional write and read; checks results after the edge
  task automatic step(bit we, int wr, int wi, logic [63:0] wd,
                      bit re, int rr, int ri, bit sg, int sew, string req);
    int wpos, rpos;
    bit woob, roob;
    logic [63:0] exp_rd;
    wpos = flat_pos(wr, wi, sew);
    rpos = flat_pos(rr, ri, sew);
    woob = wpos >= TOTAL;
    roob = rpos >= TOTAL;
    exp_rd = (re && !roob) ? model_read(rpos, sew, sg) : 64'd0;
    cfg_sew = 2'(sew);
    wr_en = we; wr_reg = REG_W'(wr); wr_idx = IDX_W'(wi); wr_data = wd;
    rd_en = re; rd_reg = REG_W'(rr); rd_idx = IDX_W'(ri); rd_signed = sg;
    if (we && !woob) begin
      for (int k = 0; k < (1 << sew); k++) model[wpos + k] = wd[8*k +: 8];
      mflags[wpos / BPR] = 1'b1;
    end
    if (re && !roob) mflags[rpos / BPR] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    if (re) begin
      chk({req, " R5 data"}, rd_data, exp_rd);
      chk({req, " R8 rd_err"}, 64'(rd_err), 64'(roob));
    end
    if (we) chk({req, " R8 wr_err"}, 64'(wr_err), 64'(woob));
    chk({req, " R7 flags"}, 64'(ref_flags), 64'(mflags));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] keep;
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flags after reset", 64'(ref_flags), 64'd0);

    // fill the whole file with 64-bit elements
    for (int i = 0; i < TOTAL / 8; i++)
      step(1, 0, i, {$urandom, $urandom}, 0, 0, 0, 0, 3, "fill R2");

    // second reset: flags clear, contents stay (R1)
    rst_n = 1'b0; mflags = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flags clear", 64'(ref_flags), 64'd0);
    step(0, 0, 0, 0, 1, 5, 1, 0, 3, "R1 contents kept");

    // R3 spill alias: reg2 idx9 at 16-bit is reg3 slot1
    step(1, 2, 9, 64'h1234_5678_9ABC_BEEF, 0, 0, 0, 0, 1, "R9 wide data");
    step(0, 0, 0, 0, 1, 3, 1, 0, 1, "R3 spill alias");
    chk("R3 alias value", rd_data, 64'h0000_0000_0000_BEEF);
    step(0, 0, 0, 0, 1, 3, 2, 0, 0, "R3 low byte order");
    chk("R3 low byte", rd_data, 64'hEF);
    step(0, 0, 0, 0, 1, 0, 7, 0, 3, "R4 neighbour");

    // R4 single byte write seen at 64-bit width
    step(1, 4, 3, 64'h80, 0, 0, 0, 0, 0, "R4 byte write");
    step(0, 0, 0, 0, 1, 4, 0, 0, 3, "R4 word view");
    // R5 signed and unsigned narrow reads
    step(0, 0, 0, 0, 1, 4, 3, 1, 0, "R5 signed byte");
    chk("R5 sign extended", rd_data, 64'hFFFF_FFFF_FFFF_FF80);
    step(0, 0, 0, 0, 1, 4, 3, 0, 0, "R5 unsigned byte");
    chk("R5 zero extended", rd_data, 64'h80);
    keep = rd_data;
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R5 hold");
    chk("R5 rd_data holds", rd_data, keep);

    // R6 same-cycle read and write of one element
    step(1, 6, 2, 64'hDEAD_0000_CAFE_F00D, 1, 6, 2, 0, 2, "R6 read old");
    step(0, 0, 0, 0, 1, 6, 2, 0, 2, "R6 read new");
    chk("R6 new value", rd_data, 64'hCAFE_F00D);

    // R8 write just past the last register must not wrap onto reg0
    step(1, NREG-1, BPR, 64'h55, 0, 0, 0, 0, 0, "R8 oob write");
    step(0, 0, 0, 0, 1, 0, 0, 0, 3, "R8 no wrap");
    step(0, 0, 0, 0, 1, NREG-1, 2, 1, 3, "R8 oob read");
    step(0, 0, 0, 0, 1, NREG-1, 1, 0, 3, "R8 last element");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int sew, lim;
      sew = int'($urandom_range(0, 3));
      lim = (TOTAL >> sew) + 8;
      if (lim > (1 << IDX_W) - 1) lim = (1 << IDX_W) - 1;
      step(bit'($urandom_range(0, 1)), int'($urandom_range(0, NREG-1)),
           int'($urandom_range(0, lim)) >> int'($urandom_range(0, 3)), {$urandom, $urandom},
           bit'($urandom_range(0, 1)), int'($urandom_range(0, NREG-1)),
           int'($urandom_range(0, lim)) >> int'($urandom_range(0, 3)),
           bit'($urandom_range(0, 1)), sew, "random R2 R3 R4 R9");
    end
    finish_run();
  end
endmodule